// File: doc/BRIEF.md
# Byte Serial Shift Port

This block is a byte-at-a-time synchronous serial port for a small controller. Software hands it one byte through a transmit stream handshake. That byte loads the shift register at once and the transfer starts. Eight bits leave on SDO, most significant first, while eight bits arrive from SDI into the same register. When the eighth bit completes, the received byte moves into a receive holding register. Completion raises a receive-valid status and a separate interrupt flag.

In master mode the block generates SCK itself. The clock comes from a prescaler on the system clock or from a slow external clock input. In slave mode it takes SCK from its input pin through a synchronizer and a stability filter. One control bit picks the idle level of SCK. The edge leaving idle samples SDI, and the edge returning to idle moves the next bit onto SDO. With the enable low, the output enables drop so that the pins can serve as general-purpose I/O.

Back-pressure rules: `tx_ready` is high only while the port is enabled and idle. A byte moves in on a clock where `tx_valid` and `tx_ready` are both high. An offer made while a transfer runs is refused, not queued, and has no effect on that transfer. On the receive side, `rx_valid` stays high until a cycle with `rx_ready` high. The producer never waits. A byte that completes while `rx_valid` is still set overwrites the holding register and raises the sticky overrun flag.

Top module: `spi_byte_port`

## Requirements
- R1: Each transfer moves exactly 8 bits, most significant first, on SDO. The 8 bits sampled from SDI, first bit in the most significant position, appear on `rx_data` after completion.
- R2: While `en`=1 and the port is idle, `tx_ready`=1. A handshake loads `tx_data` and sets `busy` on the next clock edge, with `sdo_o` showing `tx_data[7]`.
- R3: While `busy`=1, `tx_ready`=0. A byte offered with `tx_valid`=1 during a transfer does not change the bits sent and starts no transfer.
- R4: `busy` stays 1 for the whole transfer and falls on the same clock edge that sets `rx_valid`.
- R5: Completion sets `rx_valid`=1. A cycle with `rx_valid` and `rx_ready` both high clears it.
- R6: Completion sets `irq`=1. Reading the receive byte does not clear it; only a pulse on `irq_clr` does.
- R7: If a byte completes while `rx_valid`=1 and no read takes place in that cycle, `rx_data` takes the new byte and `ovr` becomes 1. `ovr` stays 1 until a pulse on `ovr_clr`.
- R8: Rate codes 0 to 5 on `rate` give an SCK period of 4<<code system clocks in master mode, that is a half period of 2<<code.
- R9: Rate codes 6 and 7 select the external clock. Each rising edge of `ext_clk` advances SCK by one half period.
- R10: SCK idles at the level of `edge_sel`. The edge away from idle samples SDI, and the edge back to idle shifts SDO.
- R11: In slave mode an SCK pulse shorter than 3 system clocks after synchronization is ignored. Longer levels are accepted as edges.
- R12: With `en`=0, `sck_oe`, `sdo_oe` and `tx_ready` are 0. In slave mode `sck_oe` is always 0.
- R13: After a transfer, SDO keeps the last bit sent (`tx_data[0]`). In master mode SCK rests at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Port enable; 0 releases the pins |
| master | input | 1 | 1 drives SCK, 0 follows the SCK pin |
| edge_sel | input | 1 | SCK idle level and edge choice |
| rate | input | 3 | 0..5 divide by 4..128, 6/7 external clock |
| ext_clk | input | 1 | Slow external shift clock |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Port idle and enabled |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Receive byte not yet read |
| rx_ready | input | 1 | Consumer takes the receive byte |
| irq | output | 1 | Completion interrupt flag |
| irq_clr | input | 1 | Clears `irq` |
| ovr | output | 1 | Sticky overrun flag |
| ovr_clr | input | 1 | Clears `ovr` |
| busy | output | 1 | Transfer in progress |
| sck_i | input | 1 | SCK pin input (slave) |
| sck_o | output | 1 | SCK pin output (master) |
| sck_oe | output | 1 | SCK output enable |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | SDO output enable |

## Verification
The bench uses the default parameters: 8-bit transfers, rate codes up to 5 (divide by 128), a 2-flop synchronizer and a 3-clock stability window. With these values every internal divider step lies within reach, with the longest transfer about 1024 clocks. A 20-clock external period tells the external source apart from every internal rate. A single-clock glitch sits below the filter window, and 10-clock SCK levels sit well above it.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
  localparam int RATE_W = 3;

  typedef struct packed {
    logic lead;
    logic trail;
  } edge_ev_t;

  function automatic logic rate_is_ext(input logic [RATE_W-1:0] code, input int max_code);
    return int'(code) > max_code;
  endfunction
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_byte_pkg::*;
#(
  parameter int MAX_CODE = 5,
  parameter int EXT_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  input  logic              ext_clk,
  output logic              tick
);
  localparam int MAX_HALF = 2 << MAX_CODE;
  localparam int CW = $clog2(MAX_HALF) + 1;

  logic [CW-1:0] cnt, half;
  logic [EXT_SYNC:0] ext_sh;
  logic ext_sel, ext_rise, int_tick;

  assign ext_sel  = rate_is_ext(rate, MAX_CODE);
  assign half     = ext_sel ? '0 : (CW'(2) << rate);
  assign ext_rise = ext_sh[EXT_SYNC-1] & ~ext_sh[EXT_SYNC];
  assign int_tick = run && !ext_sel && (cnt == half - 1'b1);
  assign tick     = run && (ext_sel ? ext_rise : int_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_sh <= '0;
      cnt    <= '0;
    end else begin
      ext_sh <= {ext_sh[EXT_SYNC-1:0], ext_clk};
      if (!run || int_tick) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_sck_filter.sv
module spi_sck_filter #(
  parameter int SYNC_LEN   = 2,
  parameter int STABLE_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  localparam int CW = $clog2(STABLE_LEN + 1);

  logic [SYNC_LEN-1:0] sync_q;
  logic [CW-1:0] cnt;
  logic raw, accept;

  assign raw    = sync_q[SYNC_LEN-1];
  assign accept = (raw != level) && (cnt == CW'(STABLE_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt    <= '0;
      level  <= 1'b0;
      rise   <= 1'b0;
      fall   <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_LEN-2:0], pin};
      rise   <= accept && raw;
      fall   <= accept && !raw;
      if (raw == level) begin
        cnt <= '0;
      end else if (accept) begin
        level <= raw;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_byte_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         master,
  input  logic         edge_sel,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         tick,
  input  logic         f_rise,
  input  logic         f_fall,
  input  logic         sdi,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_byte,
  output logic         sdo,
  output logic         sck
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sh;
  logic [CW-1:0] bit_cnt;
  logic          samp, last;
  edge_ev_t      ev;

  always_comb begin
    if (master) begin
      ev.lead  = tick && (sck == edge_sel);
      ev.trail = tick && (sck != edge_sel);
    end else begin
      ev.lead  = edge_sel ? f_fall : f_rise;
      ev.trail = edge_sel ? f_rise : f_fall;
    end
    ev.lead  = ev.lead && busy;
    ev.trail = ev.trail && busy;
  end

  assign last    = (bit_cnt == CW'(W - 1));
  assign done    = ev.trail && last;
  assign rx_byte = {sh[W-2:0], samp};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sh      <= '0;
      bit_cnt <= '0;
      samp    <= 1'b0;
      sdo     <= 1'b0;
      sck     <= 1'b0;
    end else if (!en) begin
      busy    <= 1'b0;
      bit_cnt <= '0;
      sck     <= edge_sel;
    end else if (load) begin
      busy    <= 1'b1;
      sh      <= load_data;
      sdo     <= load_data[W-1];
      bit_cnt <= '0;
      sck     <= edge_sel;
    end else if (busy) begin
      if (master && tick) sck <= ~sck;
      if (ev.lead) samp <= sdi;
      if (ev.trail) begin
        sh <= {sh[W-2:0], samp};
        if (last) begin
          busy <= 1'b0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          sdo     <= sh[W-2];
        end
      end
    end else begin
      sck <= edge_sel;
    end
  end
endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port
  import spi_byte_pkg::*;
#(
  parameter int W          = 8,
  parameter int MAX_CODE   = 5,
  parameter int SYNC_LEN   = 2,
  parameter int STABLE_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              master,
  input  logic              edge_sel,
  input  logic [RATE_W-1:0] rate,
  input  logic              ext_clk,
  input  logic [W-1:0]      tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [W-1:0]      rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              irq,
  input  logic              irq_clr,
  output logic              ovr,
  input  logic              ovr_clr,
  output logic              busy,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe
);
  logic         load, tick, done_w, f_level, f_rise, f_fall;
  logic [W-1:0] rx_byte;

  assign tx_ready = en && !busy;
  assign load     = tx_valid && tx_ready;
  assign sck_oe   = en && master;
  assign sdo_oe   = en;

  spi_rate_gen #(.MAX_CODE(MAX_CODE), .EXT_SYNC(SYNC_LEN)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(busy && master), .rate(rate),
    .ext_clk(ext_clk), .tick(tick)
  );

  spi_sck_filter #(.SYNC_LEN(SYNC_LEN), .STABLE_LEN(STABLE_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .pin(sck_i), .level(f_level),
    .rise(f_rise), .fall(f_fall)
  );

  spi_shift_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .en(en), .master(master), .edge_sel(edge_sel),
    .load(load), .load_data(tx_data), .tick(tick), .f_rise(f_rise),
    .f_fall(f_fall), .sdi(sdi_i), .busy(busy), .done(done_w),
    .rx_byte(rx_byte), .sdo(sdo_o), .sck(sck_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
      irq      <= 1'b0;
      ovr      <= 1'b0;
    end else begin
      if (done_w) begin
        rx_data  <= rx_byte;
        rx_valid <= 1'b1;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end

      if (done_w)       irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;

      if (done_w && rx_valid && !rx_ready) ovr <= 1'b1;
      else if (ovr_clr)                    ovr <= 1'b0;
    end
  end

  logic unused_level;
  assign unused_level = f_level;
endmodule

// File: rtl/spi_byte_port_chk.sv
module spi_byte_port_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic master,
  input logic edge_sel,
  input logic tx_ready,
  input logic busy,
  input logic rx_valid,
  input logic rx_ready,
  input logic irq,
  input logic irq_clr,
  input logic ovr,
  input logic ovr_clr,
  input logic sck_o,
  input logic sck_oe,
  input logic sdo_oe,
  input logic done
);
  p_busy_refuses_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tx_ready);

  p_disabled_pins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!sck_oe && !sdo_oe && !tx_ready));

  p_slave_no_drive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> !sck_oe);

  p_done_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $fell(busy)) |-> (rx_valid && irq));

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !done) |=> !rx_valid);

  p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !ovr_clr) |=> ovr);

  p_sck_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && en && master && !busy && $stable(edge_sel)) |-> (sck_o == edge_sel));
endmodule

bind spi_byte_port spi_byte_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .master(master), .edge_sel(edge_sel),
  .tx_ready(tx_ready), .busy(busy), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .irq(irq), .irq_clr(irq_clr), .ovr(ovr), .ovr_clr(ovr_clr),
  .sck_o(sck_o), .sck_oe(sck_oe), .sdo_oe(sdo_oe), .done(done_w)
);

// File: tb/spi_byte_port_test.sv
module spi_byte_port_test;
  logic clk = 0, rst_n = 0;
  logic en = 0, master = 1, edge_sel = 0, ext_clk = 0;
  logic [2:0] rate = 0;
  logic [7:0] tx_data = 0, rx_data;
  logic tx_valid = 0, tx_ready, rx_valid, rx_ready = 0;
  logic irq, irq_clr = 0, ovr, ovr_clr = 0, busy;
  logic sck_i = 0, sck_o, sck_oe, sdi_i = 0, sdo_o, sdo_oe;

  int checks = 0, errors = 0;
  bit ext_run = 0;
  int ecnt = 0;
  bit m_rbf = 0, m_ovr = 0;

  always #10 clk = ~clk;

  spi_byte_port uut (
    .clk(clk), .rst_n(rst_n), .en(en), .master(master), .edge_sel(edge_sel),
    .rate(rate), .ext_clk(ext_clk), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .irq(irq), .irq_clr(irq_clr), .ovr(ovr),
    .ovr_clr(ovr_clr), .busy(busy), .sck_i(sck_i), .sck_o(sck_o),
    .sck_oe(sck_oe), .sdi_i(sdi_i), .sdo_o(sdo_o), .sdo_oe(sdo_oe)
  );

  always @(negedge clk) if (ext_run) begin
    ecnt++;
    if (ecnt == 10) begin ext_clk = ~ext_clk; ecnt = 0; end
  end

  function automatic int exp_half(input logic [2:0] code);
    return (code > 5) ? 20 : (2 << code);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1;
    @(negedge clk) s = 0;
  endtask

  task automatic do_read;
    pulse(rx_ready);
    m_rbf = 0;
  endtask

  task automatic xfer_master(input logic [7:0] tx, input logic [7:0] slv, input bit junk);
    logic [7:0] seen = 0;
    logic prev;
    int idx = 0, cyc = 0, t1 = 0, half = 0, nchg = 0;
    bit refused = 1;
    sdi_i = slv[7];
    @(negedge clk) begin tx_data = tx; tx_valid = 1; end
    @(negedge clk);
    chk(busy === 1 && sdo_o === tx[7], "R2 load", {busy, sdo_o}, {1'b1, tx[7]});
    tx_valid = junk; tx_data = ~tx;
    prev = sck_o;
    while (cyc < 5000) begin
      @(negedge clk); cyc++;
      if (busy && tx_ready) refused = 0;
      if (sck_o != prev) begin
        nchg++;
        if (nchg == 1) t1 = cyc;
        if (nchg == 2) half = cyc - t1;
        if (sck_o != edge_sel) seen[7-idx] = sdo_o;
        else begin idx++; if (idx < 8) sdi_i = slv[7-idx]; end
        prev = sck_o;
      end
      if (!busy) break;
    end
    tx_valid = 0;
    m_ovr = m_ovr | m_rbf; m_rbf = 1;
    chk(refused, "R3 tx_ready low while busy", 0, 0);
    chk(seen == tx, "R1 R3 R10 bits on SDO", seen, tx);
    chk(rx_data == slv, "R1 R10 received byte", rx_data, slv);
    chk(half == exp_half(rate), "R8 R9 SCK half period", half, exp_half(rate));
    chk(nchg == 16, "R1 SCK edge count", nchg, 16);
    chk(rx_valid && irq && !busy, "R4 R5 R6 completion flags", {rx_valid, irq, busy}, 3'b110);
    chk(ovr == m_ovr, "R7 overrun flag", ovr, m_ovr);
    repeat (3) @(negedge clk);
    chk(sdo_o == tx[0] && sck_o == edge_sel && !busy, "R13 idle hold", {sdo_o, sck_o}, {tx[0], edge_sel});
  endtask

  task automatic xfer_slave(input logic [7:0] tx, input logic [7:0] slv, input bit glitch);
    logic [7:0] seen = 0;
    sck_i = edge_sel;
    repeat (10) @(negedge clk);
    @(negedge clk) begin tx_data = tx; tx_valid = 1; end
    @(negedge clk) tx_valid = 0;
    chk(!sck_oe && sdo_oe, "R12 slave pin enables", {sck_oe, sdo_oe}, 2'b01);
    if (glitch) begin
      sck_i = ~edge_sel;
      @(negedge clk) sck_i = edge_sel;
      repeat (10) @(negedge clk);
    end
    for (int i = 0; i < 8; i++) begin
      sdi_i = slv[7-i];
      repeat (10) @(negedge clk);
      seen[7-i] = sdo_o;
      sck_i = ~edge_sel;
      repeat (10) @(negedge clk);
      sck_i = edge_sel;
      repeat (10) @(negedge clk);
    end
    m_ovr = m_ovr | m_rbf; m_rbf = 1;
    chk(seen == tx, "R11 slave SDO bits", seen, tx);
    chk(rx_data == slv, "R11 slave received byte", rx_data, slv);
    chk(!busy && rx_valid, "R4 slave completion", {busy, rx_valid}, 2'b01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!rx_valid && !irq && !ovr && !busy, "R5 reset flags", {rx_valid, irq, ovr, busy}, 0);
    chk(!tx_ready && !sck_oe && !sdo_oe, "R12 disabled after reset", {tx_ready, sck_oe, sdo_oe}, 0);

    en = 1;
    @(negedge clk);
    chk(tx_ready && sck_oe && sdo_oe, "R2 R12 enabled idle", {tx_ready, sck_oe, sdo_oe}, 3'b111);

    xfer_master(8'hA5, 8'h3C, 0);
    do_read;
    chk(!rx_valid, "R5 read clears", rx_valid, 0);
    chk(irq, "R6 irq kept after read", irq, 1);
    pulse(irq_clr);
    chk(!irq, "R6 irq_clr", irq, 0);

    rate = 1;
    xfer_master(8'h81, 8'h7E, 0);
    xfer_master(8'h5A, 8'hC3, 1);
    chk(ovr && rx_data == 8'hC3, "R7 overwrite", {ovr, rx_data}, {1'b1, 8'hC3});
    pulse(ovr_clr); m_ovr = 0;
    chk(!ovr, "R7 ovr_clr", ovr, 0);
    do_read; pulse(irq_clr);

    edge_sel = 1; rate = 2;
    repeat (2) @(negedge clk);
    chk(sck_o == 1, "R10 idle high", sck_o, 1);
    xfer_master(8'h96, 8'h0F, 0);
    do_read;

    rate = 6; ext_run = 1; edge_sel = 0;
    xfer_master(8'h3E, 8'hE1, 0);
    do_read; ext_run = 0;

    master = 0; rate = 0;
    xfer_slave(8'hB4, 8'h4B, 1);
    do_read;
    edge_sel = 1;
    xfer_slave(8'h17, 8'hE8, 1);
    do_read;
    master = 1; edge_sel = 0;

    en = 0; tx_valid = 1; tx_data = 8'hFF;
    repeat (3) @(negedge clk);
    chk(!tx_ready && !sck_oe && !sdo_oe, "R12 disabled pins", {tx_ready, sck_oe, sdo_oe}, 0);
    tx_valid = 0; en = 1;
    @(negedge clk);
    chk(!busy, "R12 no start while disabled", busy, 0);

    for (int n = 0; n < 16; n++) begin
      rate = 3'($urandom_range(0, 5));
      edge_sel = 1'($urandom_range(0, 1));
      repeat (2) @(negedge clk);
      xfer_master(8'($urandom), 8'($urandom), 1'($urandom_range(0, 1)));
      do_read; pulse(irq_clr);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule